// File: doc/BRIEF.md
# Infrared Carrier Duty Generator

This block produces the square-wave carrier used by infrared remote-control transmitters. An 8-bit up-counter starts at a programmable reload value and counts one step per input clock. When it passes its maximum value of 255, it wraps back to the reload value. Each trip from the reload value up to 255 is one carrier period, so the period is 256 minus the reload value, measured in input clocks.

A second programmable value, the duty compare, splits each period in two. The carrier is high from the start of the period until the counter reaches the compare value. It is low from that point until the wrap. So the high width is compare minus reload and the low width is 256 minus compare. For example, reload 151 with compare 186 on a 4 MHz clock gives a 105-clock period, about 38 kHz, with a high phase of about one third. To get a wanted duty fraction f, pick compare = reload + (256 - reload) * f.

Software writes new values through simple write strobes. A written value sits in a staging register and is copied into the active registers only at a period boundary, or at any time while the block is disabled. A rewrite in the middle of a period therefore never truncates or glitches the current period. When the block is disabled, the carrier is held low and the counter is parked at the reload value. When it is enabled again, the carrier starts with a full high phase.

Top module: `ir_carrier_gen`

## Requirements
- R1: During reset and after reset release, with enable low, `carrier_out` is 0. Both the staged and the active reload and compare values reset to 0.
- R2: While enabled, the counter rises by one per clock. After the cycle in which it holds 255, it takes the reload value. The carrier period is therefore 256 minus the reload value, in clocks.
- R3: In every enabled period with compare greater than reload, `carrier_out` is high for exactly (compare - reload) consecutive clocks, starting at the period boundary.
- R4: The low phase that follows the high phase lasts exactly (256 - compare) clocks and ends at the wrap. The clock after the counter holds 255 always shows the carrier low.
- R5: A write of `reload_wdata` on `reload_we`, or of `duty_wdata` on `duty_we`, made while enabled does not change the period in progress. The new values take effect from the next period boundary onward.
- R6: While `enable` is low, the counter is held at the staged reload value, the staged values are copied to the active registers, and `carrier_out` is 0 from the clock after enable falls.
- R7: After `enable` rises, `carrier_out` goes high one clock later, and that first high phase has the full width (compare - reload).
- R8: If the compare value is less than or equal to the reload value, `carrier_out` stays low for the whole period, on every period.
- R9: With a compare value of 255, the low phase lasts exactly one clock in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the counter advances once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| enable | input | 1 | Runs the carrier when high; parks it low when low |
| reload_we | input | 1 | Write strobe for the staged reload value |
| reload_wdata | input | 8 | Reload value (period = 256 - value) |
| duty_we | input | 1 | Write strobe for the staged duty compare value |
| duty_wdata | input | 8 | Duty compare value (high/low boundary) |
| carrier_out | output | 1 | Registered carrier output |

## Verification
The scoreboard measures every high run and low run of the carrier over several periods. It does this for several reload/compare pairs, including a compare of 255. A counter that reloads one step late or early, or a compare that is off by one, changes these widths by one clock and is caught.

A rewrite is made in the middle of a high phase. A design without shadowing would shorten or stretch that period, or raise the carrier again during its low phase.

Compare values at or below the reload value are held for two full periods. A design with a wrong comparison would emit stray high pulses there.

Re-enabling after a disable must give a full first high phase one clock after enable. A design that resumed the counter from where it stopped would produce a short first pulse.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  // Width of counter, reload and compare values.
  parameter int unsigned CNT_W = 8;

  // State of the registered output stage.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } ir_phase_e;

endpackage

// File: rtl/ir_carrier_regs.sv
module ir_carrier_regs
  import ir_carrier_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         duty_we,
  input  logic [W-1:0] duty_wdata,
  input  logic         load_act,
  output logic [W-1:0] reload_stg_o,
  output logic [W-1:0] reload_act_o,
  output logic [W-1:0] duty_act_o
);

  logic [W-1:0] reload_stg_q, reload_stg_d;
  logic [W-1:0] duty_stg_q,   duty_stg_d;
  logic [W-1:0] reload_act_q, reload_act_d;
  logic [W-1:0] duty_act_q,   duty_act_d;

  // Next-state: staging follows write strobes, active follows load_act.
  always_comb begin
    reload_stg_d = reload_stg_q;
    duty_stg_d   = duty_stg_q;
    reload_act_d = reload_act_q;
    duty_act_d   = duty_act_q;
    if (reload_we) reload_stg_d = reload_wdata;
    if (duty_we)   duty_stg_d   = duty_wdata;
    if (load_act) begin
      reload_act_d = reload_stg_q;
      duty_act_d   = duty_stg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_stg_q <= '0;
      duty_stg_q   <= '0;
      reload_act_q <= '0;
      duty_act_q   <= '0;
    end else begin
      if (reload_we) reload_stg_q <= reload_stg_d;
      if (duty_we)   duty_stg_q   <= duty_stg_d;
      if (load_act) begin
        reload_act_q <= reload_act_d;
        duty_act_q   <= duty_act_d;
      end
    end
  end

  assign reload_stg_o = reload_stg_q;
  assign reload_act_o = reload_act_q;
  assign duty_act_o   = duty_act_q;

  // Active values hold whenever no load is requested.
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_act |=> ($stable(reload_act_q) && $stable(duty_act_q)));

endmodule

// File: rtl/ir_carrier_counter.sv
module ir_carrier_counter
  import ir_carrier_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;

  assign at_top = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!enable) begin
      cnt_d = reload_val;
    end else if (at_top) begin
      cnt_d = reload_val;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = enable && at_top;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt_q == CNT_MAX) |=> (cnt_q == $past(reload_val)));

  assert_hold_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/ir_carrier_phase.sv
module ir_carrier_phase
  import ir_carrier_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  output logic         out_o
);

  ir_phase_e phase_q, phase_d;

  always_comb begin
    if (!enable)          phase_d = PH_IDLE;
    else if (cnt < duty)  phase_d = PH_HIGH;
    else                  phase_d = PH_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign out_o = (phase_q == PH_HIGH);

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_o);

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         duty_we,
  input  logic [W-1:0] duty_wdata,
  output logic         carrier_out
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] reload_stg;
  logic [W-1:0] reload_act;
  logic [W-1:0] duty_act;
  logic [W-1:0] cnt;
  logic         wrap;
  logic         load_act;

  assign load_act = !enable || wrap;

  ir_carrier_regs #(.W(W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reload_we    (reload_we),
    .reload_wdata (reload_wdata),
    .duty_we      (duty_we),
    .duty_wdata   (duty_wdata),
    .load_act     (load_act),
    .reload_stg_o (reload_stg),
    .reload_act_o (reload_act),
    .duty_act_o   (duty_act)
  );

  ir_carrier_counter #(.W(W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .reload_val (reload_stg),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  ir_carrier_phase #(.W(W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .cnt    (cnt),
    .duty   (duty_act),
    .out_o  (carrier_out)
  );

  // The cycle after the counter sits at its top, the carrier is low.
  assert_low_after_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt == CNT_MAX) |=> !carrier_out);

  // Compare at or below reload never yields a high cycle.
  assert_duty_le_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && duty_act <= reload_act) |=> !carrier_out);

  // The counter never sits below the active reload value while running.
  assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> (cnt >= reload_act));

endmodule

// File: tb/ir_carrier_gen_tb_top.sv
`timescale 1ns/1ps
module ir_carrier_gen_tb_top;

  typedef struct {
    bit level;
    int width;
    int req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       reload_we;
  logic [7:0] reload_wdata;
  logic       duty_we;
  logic [7:0] duty_wdata;
  logic       carrier_out;

  int   tests_run;
  int   tests_failed;
  exp_t sb_q[$];
  bit   sync_req;
  bit   tracking;
  bit   prev_lvl;
  int   run_len;
  bit   done;

  ir_carrier_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .reload_we    (reload_we),
    .reload_wdata (reload_wdata),
    .duty_we      (duty_we),
    .duty_wdata   (duty_wdata),
    .carrier_out  (carrier_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_cfg(input int r, input int d);
    reload_we    = 1'b1;
    reload_wdata = 8'(r);
    duty_we      = 1'b1;
    duty_wdata   = 8'(d);
    step(1);
    reload_we    = 1'b0;
    duty_we      = 1'b0;
  endtask

  task automatic push_pairs(input int r, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      sb_q.push_back('{level: 1'b1, width: d - r, req: 3});
      sb_q.push_back('{level: 1'b0, width: 256 - d, req: (d == 255) ? 9 : 4});
    end
  endtask

  task automatic wait_drain();
    while (sb_q.size() != 0 && !done) step(1);
  endtask

  // Driver: program while disabled, queue expected widths, run until drained.
  task automatic run_pairs(input int r, input int d, input int n);
    write_cfg(r, d);
    step(2);
    push_pairs(r, d, n);
    sync_req = 1'b1;
    enable   = 1'b1;
    wait_drain();
    enable = 1'b0;
    step(3);
  endtask

  // Monitor: measure run lengths at the falling edge and compare.
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len  = 0;
      prev_lvl = 1'b0;
      tracking = 1'b0;
    end else begin
      if (carrier_out !== prev_lvl) begin
        if (tracking && sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.level == prev_lvl && e.width == run_len,
                $sformatf("R%0d width(level %0d)", e.req, prev_lvl), run_len, e.width);
        end
        if (sync_req && carrier_out === 1'b1) begin
          tracking = 1'b1;
          sync_req = 1'b0;
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      if (sb_q.size() == 0) tracking = 1'b0;
      prev_lvl = carrier_out;
    end
  end

  initial begin
    done = 1'b0;
    #(5.0 * 150000);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    int highs;
    tests_run    = 0;
    tests_failed = 0;
    sync_req     = 1'b0;
    rst_n        = 1'b0;
    enable       = 1'b0;
    reload_we    = 1'b0;
    reload_wdata = '0;
    duty_we      = 1'b0;
    duty_wdata   = '0;
    #1;
    step(4);
    check(carrier_out === 1'b0, "R1 out in reset", int'(carrier_out), 0);
    rst_n = 1'b1;
    step(5);
    check(carrier_out === 1'b0, "R1 out after reset", int'(carrier_out), 0);
    // Enabling with reset values (reload 0, compare 0) must stay low.
    enable = 1'b1;
    highs = 0;
    for (int i = 0; i < 300; i++) begin step(1); if (carrier_out) highs++; end
    check(highs == 0, "R1 reset compare/reload give no high", highs, 0);
    enable = 1'b0;
    step(3);

    // R7: first high appears one clock after enable.
    write_cfg(151, 186);
    step(2);
    push_pairs(151, 186, 4);
    sync_req = 1'b1;
    enable   = 1'b1;
    @(negedge clk);
    check(carrier_out === 1'b0, "R7 low in enable cycle", int'(carrier_out), 0);
    @(negedge clk);
    check(carrier_out === 1'b1, "R7 high one clock after enable", int'(carrier_out), 1);
    #1;
    wait_drain();
    enable = 1'b0;
    step(1);
    @(negedge clk);
    check(carrier_out === 1'b0, "R6 low after disable", int'(carrier_out), 0);
    #1;
    highs = 0;
    for (int i = 0; i < 300; i++) begin step(1); if (carrier_out) highs++; end
    check(highs == 0, "R6 stays low while disabled", highs, 0);

    // R2/R3/R4/R9: several pairs.
    run_pairs(131, 193, 3);
    run_pairs(200, 220, 3);
    run_pairs(100, 255, 3);
    run_pairs(0, 128, 2);

    // R7 again after re-enable: full first high phase (covered by queue).
    run_pairs(185, 208, 2);

    // R5: rewrite during the high phase of the third period.
    write_cfg(151, 186);
    step(2);
    push_pairs(151, 186, 3);
    sb_q.push_back('{level: 1'b1, width: 208 - 185, req: 5});
    sb_q.push_back('{level: 1'b0, width: 256 - 208, req: 5});
    sb_q.push_back('{level: 1'b1, width: 208 - 185, req: 5});
    sb_q.push_back('{level: 1'b0, width: 256 - 208, req: 5});
    sync_req = 1'b1;
    enable   = 1'b1;
    while (sb_q.size() > 6 && !done) step(1);
    step(3);
    write_cfg(185, 208);
    wait_drain();
    enable = 1'b0;
    step(3);

    // R8: compare below and equal to reload.
    write_cfg(200, 150);
    step(2);
    enable = 1'b1;
    highs = 0;
    for (int i = 0; i < 2 * 56 + 5; i++) begin step(1); if (carrier_out) highs++; end
    check(highs == 0, "R8 compare below reload", highs, 0);
    enable = 1'b0;
    step(3);
    write_cfg(120, 120);
    step(2);
    enable = 1'b1;
    highs = 0;
    for (int i = 0; i < 2 * 136 + 5; i++) begin step(1); if (carrier_out) highs++; end
    check(highs == 0, "R8 compare equal to reload", highs, 0);
    enable = 1'b0;
    step(3);

    check(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule